// File: doc/BRIEF.md
# Flash Boot Command Interpreter

This block sits behind the boot-area write port of a flash device that boots straight from memory. It watches 16-bit word writes into two address windows, a low boot window and a small secondary window, and treats each write that lands in either window as a boot command. Single-cycle commands reset the device or copy identification bytes into the first words of the boot buffer. A two-cycle command loads a page: an arming write followed by a zero write. The zero write issues a page-load request to the external array interface.

The page-load request carries a sector number built from the current block and page registers. It stays raised until the array interface acknowledges it. While the load or the identification fill is in progress, the block reports busy and drops further boot writes. Each completed load advances the page register by four sectors' worth, wrapping within eight bits, so repeated loads walk through consecutive pages. Array timing and the data transfer itself stay outside the block.

Top module: `flash_boot_cmd`

## Requirements
- R1: A write is a boot command only when its word offset lies in 0x0000..0x01FF or 0x8000..0x800F; any other offset produces no strobe, no request and no arming.
- R2: Command value 0x00F0 raises `dev_reset` for exactly one cycle, starting the cycle after the write, and clears `page_addr` to 0.
- R3: Command value 0x00E0 arms the load; if the next boot write carries 0x0000, `ld_req` rises the cycle after that write.
- R4: The boot write that follows an arming write always disarms. A nonzero value there starts no load and raises no error, and a later 0x0000 write is then treated as an unknown command.
- R5: `ld_sector` equals (page & 3) + ({blk, page[7:2]} << 2), where blk is `blk_num`, ORed with the DENSITY_MASK parameter when `blk_upper` is 1.
- R6: When an acknowledge is seen on a raised request, `page_addr` becomes (page_addr + 4) mod 256 and `ld_req` falls.
- R7: Command value 0x0090 writes boot buffer words 0, 1 and 2 on three consecutive cycles, starting the cycle after the write. The words carry {8'h00, MFR_ID}, {8'h00, DEV_ID} and {8'h00, `wp_status`}.
- R8: Any other boot command value raises `cmd_err` for one cycle and has no other effect.
- R9: `ld_req` and `ld_sector` hold steady until `ld_ack`. `busy` is high during a load or an identify fill, and boot writes arriving then are ignored.
- R10: A `page_set` in the same cycle as a load acknowledge or a reset command wins; `page_addr` takes `page_val`.
- R11: After reset, `page_addr` is 0 and `busy`, `ld_req`, `buf_we`, `dev_reset` and `cmd_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 16 | Word offset of the write |
| wr_data | input | 16 | Written value |
| busy | output | 1 | Load or identify fill in progress; boot writes dropped |
| blk_num | input | 12 | Block number bits |
| blk_upper | input | 1 | Selects the upper density half |
| page_set | input | 1 | Load the page register |
| page_val | input | 8 | Value for the page register |
| page_addr | output | 8 | Current page register |
| wp_status | input | 8 | Low byte of the write-protect status |
| ld_req | output | 1 | Page-load request to the array |
| ld_sector | output | SECT_W | Sector number of the requested load |
| ld_ack | input | 1 | Array accepted the load |
| buf_we | output | 1 | Boot buffer word write |
| buf_idx | output | 2 | Boot buffer word index |
| buf_wdata | output | 16 | Boot buffer word data |
| dev_reset | output | 1 | One-cycle device reset strobe |
| cmd_err | output | 1 | One-cycle unknown-command strobe |

## Verification
Two things can hit the page register in the same cycle: the load-completion increment and an external page set. A page set alone can also meet the clear from a reset command. The bench raises `page_set` on the same edge as `ld_ack`, and on the same edge as the write that turns into a reset. It then checks that `page_addr` holds the set value and neither the incremented value nor zero. A second overlap is a boot write that arrives while a load or identify fill is busy. The bench judges it by watching for a strobe or a changed request at the ports.

// File: rtl/flash_boot_cmd.sv
module flash_boot_cmd #(
  parameter int SECT_W = 22,
  parameter logic [12:0] DENSITY_MASK = 13'h1000,
  parameter logic [7:0] MFR_ID = 8'hEC,
  parameter logic [7:0] DEV_ID = 8'h58
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [15:0]       wr_addr,
  input  logic [15:0]       wr_data,
  output logic              busy,
  input  logic [11:0]       blk_num,
  input  logic              blk_upper,
  input  logic              page_set,
  input  logic [7:0]        page_val,
  output logic [7:0]        page_addr,
  input  logic [7:0]        wp_status,
  output logic              ld_req,
  output logic [SECT_W-1:0] ld_sector,
  input  logic              ld_ack,
  output logic              buf_we,
  output logic [1:0]        buf_idx,
  output logic [15:0]       buf_wdata,
  output logic              dev_reset,
  output logic              cmd_err
);

  localparam logic [15:0] CMD_RST   = 16'h00F0;
  localparam logic [15:0] CMD_ARM   = 16'h00E0;
  localparam logic [15:0] CMD_IDENT = 16'h0090;

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_IDENT} state_t;

  state_t state;
  logic armed;
  logic [1:0] id_cnt;

  wire in_win = (wr_addr <= 16'h01FF) ||
                (wr_addr >= 16'h8000 && wr_addr <= 16'h800F);
  wire cmd_go = wr_en && in_win && (state == S_IDLE);

  wire [12:0] blk_bits = {1'b0, blk_num} | (blk_upper ? DENSITY_MASK : 13'h0);
  wire [SECT_W-1:0] sec_calc = SECT_W'(page_addr[1:0]) +
                               (SECT_W'({blk_bits, page_addr[7:2]}) << 2);

  wire do_load  = cmd_go && armed && (wr_data == 16'h0000);
  wire do_rst   = cmd_go && !armed && (wr_data == CMD_RST);
  wire do_ident = cmd_go && !armed && (wr_data == CMD_IDENT);
  wire do_arm   = cmd_go && !armed && (wr_data == CMD_ARM);
  wire do_err   = cmd_go && !armed && !(wr_data == CMD_RST ||
                  wr_data == CMD_IDENT || wr_data == CMD_ARM);
  wire ld_done  = (state == S_LOAD) && ld_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      armed     <= 1'b0;
      id_cnt    <= 2'd0;
      page_addr <= 8'h00;
      ld_sector <= '0;
      dev_reset <= 1'b0;
      cmd_err   <= 1'b0;
    end else begin
      dev_reset <= do_rst;
      cmd_err   <= do_err;
      if (cmd_go) armed <= do_arm;

      if (page_set)     page_addr <= page_val;
      else if (do_rst)  page_addr <= 8'h00;
      else if (ld_done) page_addr <= page_addr + 8'd4;

      case (state)
        S_IDLE: begin
          if (do_load) begin
            state     <= S_LOAD;
            ld_sector <= sec_calc;
          end else if (do_ident) begin
            state  <= S_IDENT;
            id_cnt <= 2'd0;
          end
        end
        S_LOAD:  if (ld_ack) state <= S_IDLE;
        S_IDENT: begin
          if (id_cnt == 2'd2) state <= S_IDLE;
          id_cnt <= id_cnt + 2'd1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy    = (state != S_IDLE);
  assign ld_req  = (state == S_LOAD);
  assign buf_we  = (state == S_IDENT);
  assign buf_idx = id_cnt;

  always_comb begin
    case (id_cnt)
      2'd0:    buf_wdata = {8'h00, MFR_ID};
      2'd1:    buf_wdata = {8'h00, DEV_ID};
      default: buf_wdata = {8'h00, wp_status};
    endcase
  end

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && !ld_ack |=> ld_req && $stable(ld_sector));

  p_page_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_req && ld_ack && !page_set |=> page_addr == $past(page_addr) + 8'd4);

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    page_set |=> page_addr == $past(page_val));

  p_rst_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_reset && !$past(page_set) |-> page_addr == 8'h00);

  p_one_effect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_reset, cmd_err, $rose(ld_req), $rose(buf_we)}));

  p_idx_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> buf_idx <= 2'd2);

  p_busy_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> !dev_reset && !cmd_err);

endmodule

// File: tb/flash_boot_cmd_bench.sv
module flash_boot_cmd_bench;
  localparam int SECT_W = 22;
  localparam logic [12:0] DMASK = 13'h1000;
  localparam logic [7:0] MFR = 8'hEC;
  localparam logic [7:0] DEV = 8'h58;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [15:0] wr_addr = '0, wr_data = '0;
  logic busy;
  logic [11:0] blk_num = '0;
  logic blk_upper = 1'b0;
  logic page_set = 1'b0;
  logic [7:0] page_val = '0;
  logic [7:0] page_addr;
  logic [7:0] wp_status = 8'h04;
  logic ld_req, ld_ack = 1'b0;
  logic [SECT_W-1:0] ld_sector;
  logic buf_we;
  logic [1:0] buf_idx;
  logic [15:0] buf_wdata;
  logic dev_reset, cmd_err;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_boot_cmd #(.SECT_W(SECT_W), .DENSITY_MASK(DMASK), .MFR_ID(MFR), .DEV_ID(DEV))
  u_flash_boot_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .blk_num(blk_num), .blk_upper(blk_upper), .page_set(page_set),
    .page_val(page_val), .page_addr(page_addr), .wp_status(wp_status),
    .ld_req(ld_req), .ld_sector(ld_sector), .ld_ack(ld_ack), .buf_we(buf_we),
    .buf_idx(buf_idx), .buf_wdata(buf_wdata), .dev_reset(dev_reset), .cmd_err(cmd_err));

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  function automatic logic [SECT_W-1:0] exp_sec(input logic [11:0] b, input logic up,
                                                input logic [7:0] p);
    longint blk;
    blk = longint'(b) | (up ? longint'(DMASK) : 0);
    return SECT_W'(longint'(p & 8'h3) + ((longint'(p >> 2) + blk * 64) * 4));
  endfunction

  // {addr, data, cmd_err, dev_reset, ld_req}
  localparam logic [34:0] VEC [8] = '{
    {16'h0010, 16'h1234, 3'b100},
    {16'h8005, 16'h00AB, 3'b100},
    {16'h0200, 16'h00F0, 3'b000},
    {16'h800F, 16'h00F0, 3'b010},
    {16'h8010, 16'h0055, 3'b000},
    {16'h01FF, 16'h00E0, 3'b000},
    {16'h0000, 16'h0001, 3'b000},
    {16'h0000, 16'h0000, 3'b100}
  };

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [SECT_W-1:0] es;
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 page", page_addr, 0);
    chk("R11 outs", {busy, ld_req, buf_we, dev_reset, cmd_err}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R1 R2 R4 R8 vector walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][34:19], VEC[i][18:3]);
      chk("R1/R2/R4/R8 vec", {cmd_err, dev_reset, ld_req}, VEC[i][2:0]);
    end
    tick;
    chk("R8 err one cycle", cmd_err, 0);

    // R3 R5 R9 load
    @(negedge clk); blk_num = 12'h003; page_set = 1'b1; page_val = 8'h25;
    @(negedge clk); page_set = 1'b0;
    es = exp_sec(12'h003, 1'b0, 8'h25);
    wr(16'h0004, 16'h00E0);
    wr(16'h0004, 16'h0000);
    chk("R3 req", ld_req, 1);
    chk("R5 sector", ld_sector, es);
    chk("R9 busy", busy, 1);
    wr(16'h0000, 16'h00F0);
    chk("R9 ignored write", {dev_reset, cmd_err}, 0);
    @(negedge clk); blk_num = 12'hABC;
    tick; tick;
    chk("R9 held", ld_req, 1);
    chk("R9 sector stable", ld_sector, es);
    @(negedge clk); ld_ack = 1'b1;
    @(posedge clk); #1; ld_ack = 1'b0;
    chk("R6 req fall", ld_req, 0);
    chk("R6 page+4", page_addr, 8'h29);
    chk("R9 not busy", busy, 0);

    // R5 density and R6 wrap
    @(negedge clk); blk_num = 12'h001; blk_upper = 1'b1; page_set = 1'b1; page_val = 8'hFE;
    @(negedge clk); page_set = 1'b0;
    wr(16'h8000, 16'h00E0);
    wr(16'h8000, 16'h0000);
    chk("R5 density sector", ld_sector, exp_sec(12'h001, 1'b1, 8'hFE));
    @(negedge clk); ld_ack = 1'b1;
    @(posedge clk); #1; ld_ack = 1'b0;
    chk("R6 wrap", page_addr, 8'h02);

    // R10 set wins over increment
    wr(16'h0000, 16'h00E0);
    wr(16'h0000, 16'h0000);
    @(negedge clk); ld_ack = 1'b1; page_set = 1'b1; page_val = 8'h40;
    @(posedge clk); #1; ld_ack = 1'b0; page_set = 1'b0;
    chk("R10 set vs ack", page_addr, 8'h40);

    // R2 reset clears page; R10 set wins over reset
    wr(16'h0001, 16'h00F0);
    chk("R2 strobe", dev_reset, 1);
    chk("R2 page clear", page_addr, 0);
    tick;
    chk("R2 one cycle", dev_reset, 0);
    @(negedge clk); page_set = 1'b1; page_val = 8'h33;
    wr_en = 1'b1; wr_addr = 16'h0001; wr_data = 16'h00F0;
    @(posedge clk); #1; wr_en = 1'b0; page_set = 1'b0;
    chk("R10 set vs reset", page_addr, 8'h33);

    // R7 identify
    wr(16'h0100, 16'h0090);
    chk("R7 w0", {buf_we, buf_idx, buf_wdata}, {1'b1, 2'd0, 8'h00, MFR});
    chk("R9 busy ident", busy, 1);
    tick;
    chk("R7 w1", {buf_we, buf_idx, buf_wdata}, {1'b1, 2'd1, 8'h00, DEV});
    tick;
    chk("R7 w2", {buf_we, buf_idx, buf_wdata}, {1'b1, 2'd2, 8'h00, 8'h04});
    tick;
    chk("R7 done", {buf_we, busy}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule